// File: doc/BRIEF.md
# CPU Clock Path Select Controller

This block chooses the clock path feeding one CPU cluster. It owns the select codes of two cascaded clock muxes and the target rate handed to the cluster's primary PLL. The primary mux picks one of four legs: the secondary mux, the primary PLL directly, an adaptive-distribution leg, or an alternate PLL. The secondary mux picks one of three sources: the crystal, the PLL output divided by two, or an auxiliary source.

A rate request (in MHz) arrives on a valid/ready handshake. A rate at or above the division threshold is served straight from the PLL through the adaptive leg. A rate between the minimum and the threshold is served by locking the PLL at twice the request and taking its half-rate output through the secondary mux. When a request is accepted, the block moves the CPU off the primary PLL before retuning starts. If the rate falls across the threshold, it moves to the divided leg, so the CPU never briefly runs at double frequency. Otherwise it moves to the alternate PLL. An external PLL sequencer then sends a commit, which applies the final path, or an abort, which puts back the codes and target that were in place before.

Top module: `cpu_clk_path_ctrl`

## Requirements
- R1: After reset, sel_word_o is 0 (crystal, secondary leg), pll_target_o is 0, req_ready_o is 1 and err_o is 0.
- R2: An accepted request below 300 MHz raises err_o in the next cycle and leaves sel_word_o, pll_target_o and req_ready_o unchanged.
- R3: A committed request of at least 300 and below 600 MHz gives pll_target_o equal to twice the request, secondary code 1 (PLL/2) and primary code 0 (secondary leg).
- R4: A committed request of 600 MHz or more gives pll_target_o equal to the request and primary code 2 (adaptive leg), with the secondary code unchanged.
- R5: sel_word_o[1:0] carries the primary code (0 secondary leg, 1 PLL direct, 2 adaptive leg, 3 alternate PLL). sel_word_o[3:2] carries the secondary code (0 crystal, 1 PLL/2, 3 auxiliary). Secondary code 2 never appears.
- R6: When a request is accepted with a new rate below 600 MHz and a last committed rate strictly above 600 MHz, the cycle after acceptance shows primary code 0 and secondary code 1, and pll_target_o shows the new target.
- R7: Any other valid accepted request shows primary code 3 (alternate PLL) in the cycle after acceptance, with the secondary code unchanged. A last committed rate of exactly 600 MHz does not trigger the R6 switch.
- R8: abort_i during a transition restores the select codes and pll_target_o that held before the request, and leaves the committed rate unchanged. abort_i takes priority over a simultaneous commit_i.
- R9: From acceptance until commit or abort, req_ready_o is 0, further requests are ignored and the outputs hold still. commit_i and abort_i have no effect while no transition is pending.
- R10: err_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Rate request valid |
| req_rate_i | input | RATE_W | Requested CPU rate in MHz |
| req_ready_o | output | 1 | Ready to accept a request (no transition pending) |
| commit_i | input | 1 | PLL retune finished; apply final path |
| abort_i | input | 1 | Rate change abandoned; restore previous path |
| sel_word_o | output | 4 | [1:0] primary mux code, [3:2] secondary mux code |
| pll_target_o | output | RATE_W | Rate in MHz the primary PLL is to lock at |
| err_o | output | 1 | One-cycle pulse on a rejected request |

## Verification
The hardest state to reach is the forced pre-change switch. It needs a committed rate strictly above 600 MHz followed by a request below 600 MHz, and its abort needs the saved codes to differ from the forced ones. Directed sequences commit a high rate, then request a low one and both abort and commit it. They also repeat this with exactly 600 MHz committed to hit the boundary. Random stimulus mixes rates from every band with commits, aborts, simultaneous commit and abort, and stray requests or events sent at the wrong moment, so that each kind of request follows each kind of committed rate.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    PM_SEC   = 2'd0,
    PM_PLL   = 2'd1,
    PM_ADAPT = 2'd2,
    PM_ALT   = 2'd3
  } pmux_e;

  typedef enum logic [1:0] {
    SM_XTAL = 2'd0,
    SM_HALF = 2'd1,
    SM_AUX  = 2'd3
  } smux_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;
endpackage

// File: rtl/cpc_rate_plan.sv
module cpc_rate_plan #(
  parameter int RATE_W  = 12,
  parameter int MIN_MHZ = 300,
  parameter int DIV_MHZ = 600
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              ok_o,
  output logic              low_o,
  output logic [RATE_W-1:0] target_o
);
  localparam logic [RATE_W-1:0] MinL = RATE_W'(MIN_MHZ);
  localparam logic [RATE_W-1:0] DivL = RATE_W'(DIV_MHZ);

  always_comb begin
    ok_o     = rate_i >= MinL;
    low_o    = rate_i < DivL;
    // low band: lock PLL at 2x, CPU runs from the /2 output
    target_o = low_o ? {rate_i[RATE_W-2:0], 1'b0} : rate_i;
  end
endmodule

// File: rtl/cpc_seq.sv
module cpc_seq
  import cpc_pkg::*;
#(
  parameter int RATE_W     = 12,
  parameter int DIV_MHZ    = 600,
  parameter int RESET_RATE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              ok_i,
  input  logic              low_i,
  input  logic [RATE_W-1:0] target_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic              ready_o,
  output pmux_e             pmux_o,
  output smux_e             smux_o,
  output logic [RATE_W-1:0] target_o,
  output logic              err_o
);
  localparam logic [RATE_W-1:0] DivL = RATE_W'(DIV_MHZ);

  st_e               st_q;
  logic [RATE_W-1:0] cur_rate_q, new_rate_q, sv_target_q;
  logic              new_low_q;
  pmux_e             sv_pmux_q;
  smux_e             sv_smux_q;
  logic              forced;

  assign ready_o = (st_q == ST_IDLE);
  // falling across the threshold: park on divided leg before retune
  assign forced  = low_i && (cur_rate_q > DivL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pmux_o      <= PM_SEC;
      smux_o      <= SM_XTAL;
      target_o    <= '0;
      err_o       <= 1'b0;
      cur_rate_q  <= RATE_W'(RESET_RATE);
      new_rate_q  <= '0;
      new_low_q   <= 1'b0;
      sv_target_q <= '0;
      sv_pmux_q   <= PM_SEC;
      sv_smux_q   <= SM_XTAL;
    end else begin
      err_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (!ok_i) begin
              err_o <= 1'b1;
            end else begin
              sv_pmux_q   <= pmux_o;
              sv_smux_q   <= smux_o;
              sv_target_q <= target_o;
              new_rate_q  <= rate_i;
              new_low_q   <= low_i;
              target_o    <= target_i;
              if (forced) begin
                pmux_o <= PM_SEC;
                smux_o <= SM_HALF;
              end else begin
                pmux_o <= PM_ALT;
              end
              st_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (abort_i) begin
            pmux_o   <= sv_pmux_q;
            smux_o   <= sv_smux_q;
            target_o <= sv_target_q;
            st_q     <= ST_IDLE;
          end else if (commit_i) begin
            cur_rate_q <= new_rate_q;
            if (new_low_q) begin
              pmux_o <= PM_SEC;
              smux_o <= SM_HALF;
            end else begin
              pmux_o <= PM_ADAPT;
            end
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpu_clk_path_ctrl.sv
module cpu_clk_path_ctrl
  import cpc_pkg::*;
#(
  parameter int RATE_W     = 12,
  parameter int MIN_MHZ    = 300,
  parameter int DIV_MHZ    = 600,
  parameter int RESET_RATE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [RATE_W-1:0] req_rate_i,
  output logic              req_ready_o,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic [3:0]        sel_word_o,
  output logic [RATE_W-1:0] pll_target_o,
  output logic              err_o
);
  logic              ok, low;
  logic [RATE_W-1:0] target;
  pmux_e             pmux;
  smux_e             smux;

  cpc_rate_plan #(
    .RATE_W (RATE_W),
    .MIN_MHZ(MIN_MHZ),
    .DIV_MHZ(DIV_MHZ)
  ) u_plan (
    .rate_i  (req_rate_i),
    .ok_o    (ok),
    .low_o   (low),
    .target_o(target)
  );

  cpc_seq #(
    .RATE_W    (RATE_W),
    .DIV_MHZ   (DIV_MHZ),
    .RESET_RATE(RESET_RATE)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .rate_i     (req_rate_i),
    .ok_i       (ok),
    .low_i      (low),
    .target_i   (target),
    .commit_i   (commit_i),
    .abort_i    (abort_i),
    .ready_o    (req_ready_o),
    .pmux_o     (pmux),
    .smux_o     (smux),
    .target_o   (pll_target_o),
    .err_o      (err_o)
  );

  assign sel_word_o = {smux, pmux};
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter int RATE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              err_o,
  input logic [3:0]        sel_word_o,
  input logic [RATE_W-1:0] pll_target_o
);
  assert_no_smux_code2_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_word_o[3:2] != 2'd2);

  assert_err_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_reject_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(sel_word_o) && $stable(pll_target_o) && req_ready_o));

  assert_wait_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> ($stable(sel_word_o) && $stable(pll_target_o)));

  assert_leave_pll_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_ready_o) |-> (sel_word_o[1:0] == 2'd3 || sel_word_o == 4'b0100));

  assert_low_band_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && sel_word_o == 4'b0100 && pll_target_o != '0)
      |-> (pll_target_o[0] == 1'b0 && pll_target_o >= RATE_W'(600) && pll_target_o < RATE_W'(1200)));
endmodule

bind cpu_clk_path_ctrl cpc_checker #(.RATE_W(RATE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .err_o       (err_o),
  .sel_word_o  (sel_word_o),
  .pll_target_o(pll_target_o)
);

// File: tb/cpu_clk_path_ctrl_tb.sv
module cpu_clk_path_ctrl_tb;
  localparam int W = 12;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [W-1:0] req_rate_i = '0;
  logic         commit_i = 1'b0;
  logic         abort_i = 1'b0;
  logic         req_ready_o, err_o;
  logic [3:0]   sel_word_o;
  logic [W-1:0] pll_target_o;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  logic [1:0]   m_p = 2'd0, m_s = 2'd0, sv_p, sv_s;
  logic [W-1:0] m_tgt = '0, sv_tgt, m_cur = '0, m_new;
  bit           m_busy = 1'b0;
  bit           m_err = 1'b0;

  cpu_clk_path_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_rate_i(req_rate_i),
    .req_ready_o(req_ready_o), .commit_i(commit_i), .abort_i(abort_i),
    .sel_word_o(sel_word_o), .pll_target_o(pll_target_o), .err_o(err_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [W-1:0] exp_target(input logic [W-1:0] r);
    return (r < 600) ? W'(r * 2) : r;
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (sel_word_o !== {m_s, m_p} || pll_target_o !== m_tgt ||
        req_ready_o !== !m_busy || err_o !== m_err) begin
      n_err++;
      $display("FAIL %s: sel=%h tgt=%0d rdy=%b err=%b expected sel=%h tgt=%0d rdy=%b err=%b",
               tag, sel_word_o, pll_target_o, req_ready_o, err_o,
               {m_s, m_p}, m_tgt, !m_busy, m_err);
    end
  endtask

  task automatic do_req(input logic [W-1:0] r, input string tag);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_rate_i  = r;
    @(posedge clk_i);
    #1;
    req_valid_i = 1'b0;
    m_err = 1'b0;
    if (!m_busy) begin
      if (r < 300) m_err = 1'b1;
      else begin
        sv_p = m_p; sv_s = m_s; sv_tgt = m_tgt;
        m_new = r;
        m_tgt = exp_target(r);
        if (r < 600 && m_cur > 600) begin m_p = 2'd0; m_s = 2'd1; end
        else m_p = 2'd3;
        m_busy = 1'b1;
      end
    end
    check(tag);
  endtask

  task automatic do_evt(input bit cm, input bit ab, input string tag);
    @(negedge clk_i);
    commit_i = cm;
    abort_i  = ab;
    @(posedge clk_i);
    #1;
    commit_i = 1'b0;
    abort_i  = 1'b0;
    m_err = 1'b0;
    if (m_busy) begin
      if (ab) begin
        m_p = sv_p; m_s = sv_s; m_tgt = sv_tgt; m_busy = 1'b0;
      end else if (cm) begin
        m_cur = m_new;
        if (m_new < 600) begin m_p = 2'd0; m_s = 2'd1; end
        else m_p = 2'd2;
        m_busy = 1'b0;
      end
    end
    check(tag);
  endtask

  task automatic idle_cycle(input string tag);
    @(posedge clk_i);
    #1;
    m_err = 1'b0;
    check(tag);
  endtask

  initial begin : watchdog
    #1500000;
    n_err++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'hC10C_5EED));
    #1;
    check("R1 reset state during reset");
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    idle_cycle("R1 reset state");

    // R2, R10: rejection and single-cycle error
    do_req(12'd299, "R2 reject 299");
    idle_cycle("R10 err drops after one cycle");
    do_req(12'd0, "R2 reject 0");
    idle_cycle("R10 err drops");

    // R9: events in idle ignored
    do_evt(1'b1, 1'b0, "R9 commit in idle ignored");
    do_evt(1'b0, 1'b1, "R9 abort in idle ignored");

    // R3 low band from reset (cur=0: not forced, R7)
    do_req(12'd300, "R7 alt during retune");
    do_req(12'd900, "R9 request while busy ignored");
    idle_cycle("R9 outputs hold while waiting");
    do_evt(1'b1, 1'b0, "R3 commit 300");

    // R4 high band, R5 fields
    do_req(12'd1500, "R7 alt for rising rate");
    do_evt(1'b1, 1'b0, "R4 commit 1500 smux kept");

    // R6 forced switch, then R8 abort restores adaptive leg
    do_req(12'd450, "R6 forced to divided leg");
    idle_cycle("R9 hold");
    do_evt(1'b0, 1'b1, "R8 abort restores");
    do_req(12'd599, "R6 forced again");
    do_evt(1'b1, 1'b1, "R8 abort beats commit");
    do_req(12'd599, "R6 forced 599");
    do_evt(1'b1, 1'b0, "R3 commit 599");

    // exactly 600 committed, then low: not forced (R7)
    do_req(12'd600, "R7 alt for 600");
    do_evt(1'b1, 1'b0, "R4 commit 600");
    do_req(12'd400, "R7 no forced switch from exactly 600");
    do_evt(1'b0, 1'b1, "R8 abort restores 600 path");
    do_req(12'd601, "R7 alt 601");
    do_evt(1'b1, 1'b0, "R4 commit 601");
    do_req(12'd300, "R6 forced from 601");
    do_evt(1'b1, 1'b0, "R3 commit 300 after force");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned op = $urandom_range(0, 9);
      logic [W-1:0] r;
      case ($urandom_range(0, 4))
        0: r = W'($urandom_range(0, 299));
        1: r = W'($urandom_range(300, 599));
        2: r = 12'd600;
        default: r = W'($urandom_range(601, 4095));
      endcase
      if (op < 4)       do_req(r, "R2 R3 R4 R6 R7 random request");
      else if (op < 7)  do_evt(1'b1, 1'b0, "R3 R4 R9 random commit");
      else if (op < 9)  do_evt(1'b0, 1'b1, "R8 random abort");
      else              do_evt(1'b1, 1'b1, "R8 random both");
      if (m_err) idle_cycle("R10 random err pulse");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule